// File: doc/BRIEF.md
# Serial Port Host Register Block

This block is the host-facing half of a simple serial port. A host reads and writes four 32-bit registers through a synchronous strobe interface. The registers are receive data, transmit data, status and control. Bytes that arrive from the line side are buffered in an eight-entry circular queue until the host pops them by reading the receive data register. A host write to the transmit data register emits its low byte on the line side as a one-cycle pulse. Bit-level serialisation, baud timing and line error detection live in a neighbouring block; the three error flags in the status word always read zero.

One level-sensitive interrupt line is driven from a sticky pending flag ANDed with an enable bit in the control register. The pending flag is raised by a transmit write and held high for as long as the receive queue holds data. A status read clears it once the queue is empty. Two small state machines carry the control flow:
- The queue-occupancy machine has the states Q_EMPTY, Q_PART and Q_FULL. Its transitions are: first push (Q_EMPTY to Q_PART); last push (Q_PART to Q_FULL when the eighth byte lands without a pop); last pop (Q_PART to Q_EMPTY when the only byte leaves without a push); pop from full (Q_FULL to Q_PART); and flush (any state to Q_EMPTY on a receive reset).
- The interrupt machine has the states INT_IDLE and INT_PEND. Its transitions are: raise (to INT_PEND on a transmit write or a non-empty queue) and acknowledge (INT_PEND to INT_IDLE on a status read once the queue is empty).

Top module: `sio_hostregs`

## Requirements
- R1: The register is selected by byte address bits [3:2], and address bits [1:0] are ignored. Index 0 is receive data, 1 is transmit data, 2 is status and 3 is control.
- R2: After reset, the status register reads 0x04, the control register reads 0, irq is 0, rx_ready is 1 and tx_valid is 0.
- R3: Received bytes are returned by reads of index 0 in arrival order, with at most 8 held. Each such read on a non-empty queue removes one byte, and bus_rdata shows that byte in the same cycle as the read strobe.
- R4: The status word encodes the following bits. Bit 0 is 1 when the queue holds at least one byte. Bit 1 is 1 when it holds 8. Bit 2 is always 1. Bit 3 is always 0. Bit 4 is the interrupt-pending flag. Bits 7:5 and 31:8 are 0.
- R5: rx_ready is 1 exactly when fewer than 8 bytes are held. A byte offered while the queue is full is discarded and changes no state.
- R6: A read of index 0 while the queue is empty returns 0 and leaves the queue empty.
- R7: A write to index 3 stores bits 0 (transmit reset), 1 (receive reset) and 4 (interrupt enable). Reads of index 3 return those bits, with every other bit 0. When bit 1 is set, the write empties the queue at that clock edge, and this takes priority over a push or pop in the same cycle.
- R8: A write to index 1 produces tx_valid=1 for exactly the next cycle, with tx_data equal to bus_wdata[7:0]. The same write sets the pending flag.
- R9: The pending flag is 1 whenever the queue is non-empty. A read of index 2 clears it at the clock edge unless the queue is still non-empty after that edge.
- R10: irq equals the pending flag AND control bit 4.
- R11: A write to index 2 changes no state.
- R12: A push and a pop in the same cycle leave the count unchanged and keep arrival order. A read of index 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, takes priority over bus_rd |
| bus_addr | input | 4 | Byte address inside the 16-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd, zero otherwise |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue can accept a byte this cycle |
| tx_valid | output | 1 | One-cycle pulse carrying a byte to transmit |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the following corner cases:
- A ninth byte arriving at a full queue. A design that let it in would overwrite the oldest byte, and the read-back order would break.
- A pop from an empty queue. A design that underflowed the count would report data that was never received.
- A status read while data is still queued. A design that cleared the pending flag regardless would drop the interrupt while bytes wait.
- A receive reset that lands in the same cycle as a push, and a push and pop in the same cycle. Here a wrong priority shows up as a stray byte or a count off by one.
- A write to the status register. It must leave every flag unchanged.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } sio_reg_e;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_e;

    typedef enum logic {
        INT_IDLE = 1'b0,
        INT_PEND = 1'b1
    } int_state_e;

    typedef struct packed {
        logic rd_rxd;
        logic wr_txd;
        logic rd_stat;
        logic wr_ctrl;
    } sio_acc_t;

    localparam int ST_RXVAL   = 0;
    localparam int ST_RXFULL  = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_TXFULL  = 3;
    localparam int ST_PEND    = 4;

    localparam int CT_TXRST = 0;
    localparam int CT_RXRST = 1;
    localparam int CT_IE    = 4;

endpackage

// File: rtl/sio_busdec.sv
module sio_busdec
    import sio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output sio_reg_e          reg_idx,
    output logic              rd_hit,
    output sio_acc_t          acc
);
    localparam int WIN_BITS = 4;

    logic in_win;

    generate
        if (ADDR_W > WIN_BITS) begin : g_wide
            assign in_win = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
        end else begin : g_exact
            assign in_win = 1'b1;
        end
    endgenerate

    always_comb begin
        reg_idx = sio_reg_e'(bus_addr[3:2]);
        rd_hit  = bus_rd && !bus_wr && in_win;
        acc     = '0;
        unique case (reg_idx)
            REG_RXD:  acc.rd_rxd  = rd_hit;
            REG_TXD:  acc.wr_txd  = bus_wr && in_win;
            REG_STAT: acc.rd_stat = rd_hit;
            REG_CTRL: acc.wr_ctrl = bus_wr && in_win;
            default:  acc         = '0;
        endcase
    end

endmodule

// File: rtl/sio_rxq.sv
module sio_rxq
    import sio_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head_data,
    output logic              q_nonempty,
    output logic              q_full,
    output logic              q_nonempty_nx
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    q_state_e          q_state, q_state_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic [PTR_W-1:0]  wpos_q, wpos_nx, rd_idx;
    logic [DATA_W-1:0] slot [DEPTH];
    logic              push_ok, pop_ok;

    // ---------- state register ----------
    always_ff @(posedge clk) begin
        if (!rst_n) q_state <= Q_EMPTY;
        else        q_state <= q_state_nx;
    end

    // ---------- next state ----------
    always_comb begin
        q_state_nx = q_state;
        unique case (q_state)
            Q_EMPTY: if (push_ok) q_state_nx = Q_PART;
            Q_PART: begin
                if (push_ok && !pop_ok && cnt_q == CNT_LAST)
                    q_state_nx = Q_FULL;
                else if (pop_ok && !push_ok && cnt_q == CNT_W'(1))
                    q_state_nx = Q_EMPTY;
            end
            Q_FULL:  if (pop_ok) q_state_nx = Q_PART;
            default: q_state_nx = Q_EMPTY;
        endcase
        if (flush) q_state_nx = Q_EMPTY;
    end

    // ---------- outputs ----------
    always_comb begin
        push_ready = (q_state != Q_FULL);
        q_full     = (q_state == Q_FULL);
        q_nonempty = (q_state != Q_EMPTY);
        push_ok    = push_valid && push_ready;
        pop_ok     = pop && q_nonempty;
        rd_idx     = wpos_q - PTR_W'(cnt_q);
        head_data  = q_nonempty ? slot[rd_idx] : '0;
    end

    // ---------- occupancy and write position ----------
    always_comb begin
        cnt_nx  = cnt_q;
        wpos_nx = wpos_q;
        if (flush) begin
            cnt_nx  = '0;
            wpos_nx = '0;
        end else begin
            if (push_ok) wpos_nx = wpos_q + PTR_W'(1);
            if (push_ok && !pop_ok)      cnt_nx = cnt_q + CNT_W'(1);
            else if (pop_ok && !push_ok) cnt_nx = cnt_q - CNT_W'(1);
        end
        q_nonempty_nx = (cnt_nx != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wpos_q <= '0;
        end else begin
            cnt_q  <= cnt_nx;
            wpos_q <= wpos_nx;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push_ok && !flush && wpos_q == PTR_W'(i))
                    slot[i] <= push_data;
            end
        end
    endgenerate

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R4
    state_count_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_state == Q_EMPTY) == (cnt_q == '0)) && ((q_state == Q_FULL) == (cnt_q == CNT_MAX)));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state == Q_EMPTY && !push_valid) |=> (q_state == Q_EMPTY));

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q_state == Q_EMPTY && cnt_q == '0));

endmodule

// File: rtl/sio_intr.sv
module sio_intr
    import sio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_tx,
    input  logic ack_rd,
    input  logic q_nonempty_nx,
    input  logic irq_en,
    output logic pend,
    output logic irq
);
    int_state_e i_state, i_state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) i_state <= INT_IDLE;
        else        i_state <= i_state_nx;
    end

    always_comb begin
        i_state_nx = i_state;
        unique case (i_state)
            INT_IDLE: if (set_tx || q_nonempty_nx) i_state_nx = INT_PEND;
            INT_PEND: if (ack_rd && !set_tx && !q_nonempty_nx) i_state_nx = INT_IDLE;
            default:  i_state_nx = INT_IDLE;
        endcase
    end

    always_comb begin
        pend = (i_state == INT_PEND);
        irq  = pend && irq_en;
    end

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !set_tx && !q_nonempty_nx) |=> !pend);

    // R8
    tx_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_tx |=> pend);

endmodule

// File: rtl/sio_hostregs.sv
module sio_hostregs
    import sio_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq
);
    sio_reg_e          reg_idx;
    logic              rd_hit;
    sio_acc_t          acc;
    logic [DATA_W-1:0] head_data;
    logic              q_nonempty, q_full, q_nonempty_nx;
    logic              pend;
    logic              flush;
    logic              ctl_txrst, ctl_rxrst, ctl_ie;
    logic [BUS_W-1:0]  stat_word, ctrl_word, rd_mux;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:DATA_W]};

    sio_busdec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .reg_idx  (reg_idx),
        .rd_hit   (rd_hit),
        .acc      (acc)
    );

    assign flush = acc.wr_ctrl && bus_wdata[CT_RXRST];

    sio_rxq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_valid    (rx_valid),
        .push_data     (rx_data),
        .push_ready    (rx_ready),
        .pop           (acc.rd_rxd),
        .flush         (flush),
        .head_data     (head_data),
        .q_nonempty    (q_nonempty),
        .q_full        (q_full),
        .q_nonempty_nx (q_nonempty_nx)
    );

    sio_intr u_intr (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_tx        (acc.wr_txd),
        .ack_rd        (acc.rd_stat),
        .q_nonempty_nx (q_nonempty_nx),
        .irq_en        (ctl_ie),
        .pend          (pend),
        .irq           (irq)
    );

    // control register: only the three defined bits are kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_txrst <= 1'b0;
            ctl_rxrst <= 1'b0;
            ctl_ie    <= 1'b0;
        end else if (acc.wr_ctrl) begin
            ctl_txrst <= bus_wdata[CT_TXRST];
            ctl_rxrst <= bus_wdata[CT_RXRST];
            ctl_ie    <= bus_wdata[CT_IE];
        end
    end

    // transmit byte pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= acc.wr_txd;
            if (acc.wr_txd) tx_data <= bus_wdata[DATA_W-1:0];
        end
    end

    always_comb begin
        stat_word             = '0;
        stat_word[ST_RXVAL]   = q_nonempty;
        stat_word[ST_RXFULL]  = q_full;
        stat_word[ST_TXEMPTY] = 1'b1;
        stat_word[ST_TXFULL]  = 1'b0;
        stat_word[ST_PEND]    = pend;

        ctrl_word             = '0;
        ctrl_word[CT_TXRST]   = ctl_txrst;
        ctrl_word[CT_RXRST]   = ctl_rxrst;
        ctrl_word[CT_IE]      = ctl_ie;

        rd_mux = '0;
        unique case (reg_idx)
            REG_RXD:  rd_mux = BUS_W'(head_data);
            REG_TXD:  rd_mux = '0;
            REG_STAT: rd_mux = stat_word;
            REG_CTRL: rd_mux = ctrl_word;
            default:  rd_mux = '0;
        endcase
        bus_rdata = rd_hit ? rd_mux : '0;
    end

    // R8
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wr_txd |=> (tx_valid && tx_data == $past(bus_wdata[DATA_W-1:0])));

    // R9
    pend_while_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_nonempty |-> pend);

    // R11
    stat_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_idx == REG_STAT && !rx_valid) |=>
            ($stable(q_nonempty) && $stable(ctrl_word) && !tx_valid));

endmodule

// File: tb/sio_hostregs_tb_top.sv
`timescale 1ns/1ps
module sio_hostregs_tb_top;

    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_rd, bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    bit [7:0] m_mem [8];
    int       m_cnt, m_pos;
    bit       m_pend, m_ie, m_txr, m_rxr, m_txv;
    bit [7:0] m_txd;

    always #2.5 clk = ~clk;

    sio_hostregs dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input bit [1:0] idx);
        logic [31:0] v = '0;
        case (idx)
            2'd0: v = (m_cnt != 0) ? {24'b0, m_mem[(m_pos - m_cnt) & 7]} : 32'h0;
            2'd1: v = 32'h0;
            2'd2: v = {27'b0, m_pend, 1'b0, 1'b1, m_cnt == 8, m_cnt != 0};
            default: v = {27'b0, m_ie, 2'b0, m_rxr, m_txr};
        endcase
        return v;
    endfunction

    // one bus/line cycle: drive at negedge, check outputs, update model after the edge
    task automatic cyc(input bit rd, input bit wr, input bit [1:0] idx, input bit [31:0] wd,
                       input bit rv, input bit [7:0] rb, input string tag);
        logic [31:0] e;
        string t;
        bit push, pop;
        @(negedge clk);
        bus_rd    = rd;
        bus_wr    = wr;
        bus_addr  = {idx, 2'($urandom)};
        bus_wdata = wd;
        rx_valid  = rv;
        rx_data   = rb;
        #1;
        if (rd && !wr) begin
            e = exp_read(idx);
            if (tag != "") t = tag;
            else case (idx)
                2'd0: t = "R3";
                2'd1: t = "R12";
                2'd2: t = "R4";
                default: t = "R7";
            endcase
            chk(bus_rdata == e, t, bus_rdata, e);
        end
        chk(rx_ready == (m_cnt < 8), "R5 rx_ready", 32'(rx_ready), 32'(m_cnt < 8));
        chk(irq == (m_pend && m_ie), "R10 irq", 32'(irq), 32'(m_pend && m_ie));
        chk(tx_valid == m_txv, "R8 tx_valid", 32'(tx_valid), 32'(m_txv));
        if (m_txv) chk(tx_data == m_txd, "R8 tx_data", 32'(tx_data), 32'(m_txd));
        @(posedge clk);
        push  = rv && (m_cnt < 8);
        pop   = rd && !wr && idx == 2'd0 && m_cnt != 0;
        m_txv = wr && idx == 2'd1;
        if (m_txv) m_txd = wd[7:0];
        if (wr && idx == 2'd3) begin
            m_txr = wd[0]; m_rxr = wd[1]; m_ie = wd[4];
        end
        if (wr && idx == 2'd3 && wd[1]) begin
            m_cnt = 0; m_pos = 0;
        end else begin
            if (push) begin
                m_mem[m_pos] = rb;
                m_pos = (m_pos + 1) & 7;
            end
            m_cnt = m_cnt + int'(push) - int'(pop);
        end
        m_pend = (m_pend && !(rd && !wr && idx == 2'd2)) || (wr && idx == 2'd1) || (m_cnt != 0);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 2'd0, 32'h0, 0, 8'h0, tag);
    endtask

    initial begin
        #(WD_CYCLES * 5.0);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_cnt = 0; m_pos = 0; m_pend = 0; m_ie = 0; m_txr = 0; m_rxr = 0; m_txv = 0; m_txd = 0;
        rst_n = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; rx_valid = 0; rx_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        // R2 reset state at the ports
        chk(rx_ready == 1'b1, "R2 rx_ready", 32'(rx_ready), 32'd1);
        chk(irq == 1'b0, "R2 irq", 32'(irq), 32'd0);
        chk(tx_valid == 1'b0, "R2 tx_valid", 32'(tx_valid), 32'd0);
        cyc(1, 0, 2'd2, 0, 0, 0, "R2 status");
        cyc(1, 0, 2'd3, 0, 0, 0, "R2 ctrl");

        // R6 empty read
        cyc(1, 0, 2'd0, 0, 0, 0, "R6 empty read");
        cyc(1, 0, 2'd2, 0, 0, 0, "R6 still empty");

        // R5 fill to 8, ninth dropped; R3 order
        for (int i = 0; i < 9; i++) cyc(0, 0, 2'd0, 0, 1, 8'hA0 + 8'(i), "");
        cyc(1, 0, 2'd2, 0, 0, 0, "R5 full status");
        for (int i = 0; i < 8; i++) cyc(1, 0, 2'd0, 0, 0, 0, "R3 drain order");
        cyc(1, 0, 2'd0, 0, 0, 0, "R5 ninth dropped");

        // R9 pending survives drain, clears on status read
        cyc(1, 0, 2'd2, 0, 0, 0, "R9 pend before ack");
        cyc(1, 0, 2'd2, 0, 0, 0, "R9 pend after ack");
        // R9 status read with data queued keeps pending
        cyc(0, 0, 2'd0, 0, 1, 8'h11, "");
        cyc(1, 0, 2'd2, 0, 0, 0, "R9 ack with data");
        cyc(1, 0, 2'd2, 0, 0, 0, "R9 still pending");
        cyc(1, 0, 2'd0, 0, 0, 0, "R3 single");

        // R10 / R8 interrupt enable and transmit
        cyc(0, 1, 2'd3, 32'hFFFF_FF10, 0, 0, "");
        cyc(1, 0, 2'd3, 0, 0, 0, "R7 ctrl readback");
        cyc(1, 0, 2'd2, 0, 0, 0, "R10 ack");
        cyc(0, 1, 2'd1, 32'h0000_01C5, 0, 0, "");
        idle("");
        cyc(1, 0, 2'd2, 0, 0, 0, "R8 pend from tx");
        idle("");

        // R11 status write ignored
        cyc(0, 1, 2'd2, 32'hFFFF_FFFF, 0, 0, "");
        cyc(1, 0, 2'd2, 0, 0, 0, "R11 status after write");
        cyc(1, 0, 2'd3, 0, 0, 0, "R11 ctrl after write");

        // R7 flush, including a push in the same cycle
        cyc(0, 0, 2'd0, 0, 1, 8'h21, "");
        cyc(0, 0, 2'd0, 0, 1, 8'h22, "");
        cyc(0, 1, 2'd3, 32'h12, 1, 8'h23, "");
        cyc(1, 0, 2'd0, 0, 0, 0, "R7 flushed");
        cyc(1, 0, 2'd3, 0, 0, 0, "R7 ctrl 0x12");

        // R12 push and pop together, R1 decode via random low address bits
        cyc(0, 0, 2'd0, 0, 1, 8'h31, "");
        cyc(0, 0, 2'd0, 0, 1, 8'h32, "");
        cyc(1, 0, 2'd0, 0, 1, 8'h33, "R12 pop with push");
        cyc(1, 0, 2'd0, 0, 1, 8'h34, "R12 pop with push");
        cyc(1, 0, 2'd1, 0, 0, 0, "R12 tx read zero");
        cyc(1, 0, 2'd2, 0, 0, 0, "R1 status decode");
        for (int i = 0; i < 3; i++) cyc(1, 0, 2'd0, 0, 0, 0, "R12 order kept");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int op = int'($urandom % 10);
            bit rv = ($urandom % 10) < 6;
            bit [7:0] rb = 8'($urandom);
            bit [31:0] wd = $urandom;
            case (op)
                0, 1, 2: cyc(1, 0, 2'd0, 0, rv, rb, "");
                3:       cyc(1, 0, 2'd2, 0, rv, rb, "");
                4:       cyc(1, 0, 2'($urandom % 2) ? 2'd3 : 2'd1, 0, rv, rb, "");
                5:       cyc(0, 1, 2'd1, wd, rv, rb, "");
                6:       cyc(0, 1, 2'd3, (($urandom % 6) == 0) ? wd : (wd & ~32'h2), rv, rb, "");
                7:       cyc(0, 1, 2'd2, wd, rv, rb, "");
                default: cyc(0, 0, 2'd0, 0, rv, rb, "");
            endcase
        end
        idle("");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule